// File: doc/BRIEF.md
# Bidirectional Common Scan Shift Register

This block is the row-scanning logic of a matrix panel driver. A row-wide register (160 rows by default) moves a scan token one row per shift step. The direction input picks whether the token walks toward the high rows or toward the low rows. A mode input either keeps the register as one long chain or cuts it into two equal half-chains that scan side by side. In split mode the second half-chain takes its serial data from a dedicated input at the boundary row.

The two end pins are bidirectional. One of them receives serial data and the other passes on the bit at the far end of the chain, so several devices can be cascaded. Their roles swap when the direction changes. A blanking input forces every row to the off code and empties the register. After blanking is released, rows stay off until the next shift step. Each row produces a 2-bit level code: 00 means off, and any other code carries the row bit combined with a frame polarity input.

The shift step is a one-cycle strobe in the `clk` domain. It stands for the falling edge of the external shift clock, so all state changes on rising edges of `clk`.

Top module: `com_scan_shifter`

## Requirements
- R1: After reset every row code is 00 and the register holds all zeros. The first shift step after reset shows only the newly entered bit in row 1 as set, if that bit is 1.
- R2: In single mode with `dir_right`=1, a step moves each row's bit to the next higher row, and row 1 takes `edge_a_in`.
- R3: In single mode with `dir_right`=0, a step moves each row's bit to the next lower row, and the top row takes `edge_b_in`.
- R4: In split mode with `dir_right`=1, row ROWS/2+1 takes `split_in` on a step, and the bit in row ROWS/2 leaves the chain. Row 1 still takes `edge_a_in`.
- R5: In split mode with `dir_right`=0, row ROWS/2 takes `split_in` on a step, and the bit in row ROWS/2+1 leaves the chain. The top row still takes `edge_b_in`.
- R6: With `dir_right`=1, `edge_b_oe`=1 and `edge_a_oe`=0, and `edge_b_out` equals the top row's bit. With `dir_right`=0, `edge_a_oe`=1 and `edge_b_oe`=0, and `edge_a_out` equals row 1's bit.
- R7: Without a step and with `blank_n` high, the register is unchanged. A serial input applied at that time has no effect.
- R8: While `blank_n` is low, every row code is 00 in the same cycle, and each clock edge clears the register.
- R9: After `blank_n` returns high, row codes stay 00 until the first step. From the cycle after that step, codes follow the register again.
- R10: When a row is not off, its code is {1, bit XOR `frame_inv`}: 2'b10 or 2'b11. Row r occupies `row_code[2r-1:2r-2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | One-cycle shift strobe |
| dir_right | input | 1 | 1: shift toward high rows, 0: toward low rows |
| split_mode | input | 1 | 1: two half-chains, 0: one chain |
| edge_a_in | input | 1 | Low-end pin, input value |
| edge_a_out | output | 1 | Low-end pin, output value |
| edge_a_oe | output | 1 | Low-end pin drives when 1 |
| edge_b_in | input | 1 | High-end pin, input value |
| edge_b_out | output | 1 | High-end pin, output value |
| edge_b_oe | output | 1 | High-end pin drives when 1 |
| split_in | input | 1 | Serial input of the second half-chain |
| blank_n | input | 1 | Active-low blanking |
| frame_inv | input | 1 | Frame polarity |
| row_code | output | 2*ROWS | Per-row level code |

## Verification
A shift step and blanking can arrive in the same cycle. When they do, blanking must win: the register clears, and the rows stay off even after release. The bench drives a vector that has both the step strobe and `blank_n` low, then releases blanking without a step. It expects all-zero codes in both cycles and a clean empty shift afterwards. The bench also moves the split-boundary entry and the end-pin entry in the same step and checks both rows at once.

// File: rtl/cscan_pkg.sv
package cscan_pkg;
    typedef enum logic {
        SHIFT_LEFT  = 1'b0,
        SHIFT_RIGHT = 1'b1
    } shift_dir_e;

    typedef enum logic [1:0] {
        LVL_OFF   = 2'b00,
        LVL_PLAIN = 2'b10,
        LVL_FLIP  = 2'b11
    } lvl_code_e;
endpackage

// File: rtl/cscan_shift_core.sv
module cscan_shift_core
    import cscan_pkg::*;
#(
    parameter int ROWS  = 160,
    parameter int SPLIT = ROWS / 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            blank_n,
    input  shift_dir_e      dir,
    input  logic            split_mode,
    input  logic            head_in,
    input  logic            tail_in,
    input  logic            mid_in,
    output logic [ROWS-1:0] bits_o,
    output logic            hold_o
);
    typedef struct packed {
        logic [ROWS-1:0] bits;
        logic            hold;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!blank_n) begin
            st_d.bits = '0;
            st_d.hold = 1'b1;
        end else if (step) begin
            st_d.hold = 1'b0;
            if (dir == SHIFT_RIGHT) begin
                st_d.bits = {st_q.bits[ROWS-2:0], head_in};
                if (split_mode) st_d.bits[SPLIT] = mid_in;
            end else begin
                st_d.bits = {tail_in, st_q.bits[ROWS-1:1]};
                if (split_mode) st_d.bits[SPLIT-1] = mid_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.bits <= '0;
            st_q.hold <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_o = st_q.bits;
    assign hold_o = st_q.hold;

    a_r2_right_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && blank_n && dir == SHIFT_RIGHT && !split_mode) |=>
        (st_q.bits[ROWS-1:1] == $past(st_q.bits[ROWS-2:0])) && (st_q.bits[0] == $past(head_in)));

    a_r3_left_walk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && blank_n && dir == SHIFT_LEFT && !split_mode) |=>
        (st_q.bits[ROWS-2:0] == $past(st_q.bits[ROWS-1:1])) && (st_q.bits[ROWS-1] == $past(tail_in)));

    a_r4_split_entry_right: assert property (@(posedge clk) disable iff (!rst_n)
        (step && blank_n && dir == SHIFT_RIGHT && split_mode) |=> st_q.bits[SPLIT] == $past(mid_in));

    a_r5_split_entry_left: assert property (@(posedge clk) disable iff (!rst_n)
        (step && blank_n && dir == SHIFT_LEFT && split_mode) |=> st_q.bits[SPLIT-1] == $past(mid_in));

    a_r7_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && !step) |=> $stable(st_q.bits));

    a_r8_blank_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |=> (st_q.bits == '0) && st_q.hold);

    a_r9_hold_until_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && blank_n && !step) |=> st_q.hold);
endmodule

// File: rtl/cscan_level_enc.sv
module cscan_level_enc
    import cscan_pkg::*;
#(
    parameter int ROWS = 160
) (
    input  logic [ROWS-1:0]   bits,
    input  logic              hold,
    input  logic              blank_n,
    input  logic              frame_inv,
    output logic [2*ROWS-1:0] codes
);
    logic show;
    assign show = blank_n && !hold;

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        always_comb begin
            if (!show)                 codes[2*g +: 2] = LVL_OFF;
            else if (bits[g] ^ frame_inv) codes[2*g +: 2] = LVL_FLIP;
            else                       codes[2*g +: 2] = LVL_PLAIN;
        end
    end
endmodule

// File: rtl/cscan_pin_roles.sv
module cscan_pin_roles
    import cscan_pkg::*;
(
    input  shift_dir_e dir,
    input  logic       low_bit,
    input  logic       high_bit,
    output logic       a_out,
    output logic       a_oe,
    output logic       b_out,
    output logic       b_oe
);
    always_comb begin
        a_out = low_bit;
        b_out = high_bit;
        a_oe  = (dir == SHIFT_LEFT);
        b_oe  = (dir == SHIFT_RIGHT);
    end
endmodule

// File: rtl/com_scan_shifter.sv
module com_scan_shifter
    import cscan_pkg::*;
#(
    parameter int ROWS = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              dir_right,
    input  logic              split_mode,
    input  logic              edge_a_in,
    output logic              edge_a_out,
    output logic              edge_a_oe,
    input  logic              edge_b_in,
    output logic              edge_b_out,
    output logic              edge_b_oe,
    input  logic              split_in,
    input  logic              blank_n,
    input  logic              frame_inv,
    output logic [2*ROWS-1:0] row_code
);
    localparam int SPLIT = ROWS / 2;

    shift_dir_e      dir;
    logic [ROWS-1:0] bits;
    logic            hold;

    assign dir = shift_dir_e'(dir_right);

    cscan_shift_core #(.ROWS(ROWS), .SPLIT(SPLIT)) i_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .blank_n    (blank_n),
        .dir        (dir),
        .split_mode (split_mode),
        .head_in    (edge_a_in),
        .tail_in    (edge_b_in),
        .mid_in     (split_in),
        .bits_o     (bits),
        .hold_o     (hold)
    );

    cscan_level_enc #(.ROWS(ROWS)) i_enc (
        .bits      (bits),
        .hold      (hold),
        .blank_n   (blank_n),
        .frame_inv (frame_inv),
        .codes     (row_code)
    );

    cscan_pin_roles i_pins (
        .dir      (dir),
        .low_bit  (bits[0]),
        .high_bit (bits[ROWS-1]),
        .a_out    (edge_a_out),
        .a_oe     (edge_a_oe),
        .b_out    (edge_b_out),
        .b_oe     (edge_b_oe)
    );

    a_r8_off_codes: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> row_code == '0);

    a_r6_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({edge_a_oe, edge_b_oe}) == 1);

    a_r6_cascade_out: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && step && dir_right && !split_mode) |=> edge_b_out == $past(bits[ROWS-2]));
endmodule

// File: tb/test_com_scan_shifter.sv
module test_com_scan_shifter;
    localparam int ROWS = 160;
    localparam int HALF = ROWS / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step = 1'b0, dir_right = 1'b0, split_mode = 1'b0;
    logic edge_a_in = 1'b0, edge_b_in = 1'b0, split_in = 1'b0;
    logic blank_n = 1'b1, frame_inv = 1'b0;
    logic edge_a_out, edge_a_oe, edge_b_out, edge_b_oe;
    logic [2*ROWS-1:0] row_code;

    always #5 clk = ~clk;

    com_scan_shifter #(.ROWS(ROWS)) i_com_scan_shifter (
        .clk(clk), .rst_n(rst_n), .step(step), .dir_right(dir_right),
        .split_mode(split_mode), .edge_a_in(edge_a_in), .edge_a_out(edge_a_out),
        .edge_a_oe(edge_a_oe), .edge_b_in(edge_b_in), .edge_b_out(edge_b_out),
        .edge_b_oe(edge_b_oe), .split_in(split_in), .blank_n(blank_n),
        .frame_inv(frame_inv), .row_code(row_code)
    );

    int checks = 0;
    int fails  = 0;
    logic [ROWS-1:0] mdl = '0;
    logic            mhold = 1'b1;

    // {dir_right, split_mode, a_in, b_in, split_in, step, blank_n, frame_inv}
    localparam int NV = 20;
    localparam logic [7:0] VEC [NV] = '{
        8'b1_0_1_0_0_1_1_0, // R2 enter 1 at row 1
        8'b1_0_0_0_0_1_1_0, // R2
        8'b1_0_1_0_0_1_1_0, // R2
        8'b1_0_1_1_1_0_1_0, // R7 inputs with no step
        8'b1_0_0_0_0_1_1_1, // R10 frame flips
        8'b0_0_0_1_0_1_1_0, // R3 enter 1 at top
        8'b0_0_0_0_0_1_1_0, // R3
        8'b0_0_1_1_0_1_1_0, // R3
        8'b0_0_0_0_0_0_1_1, // R7 idle, frame set
        8'b1_1_1_0_1_1_1_0, // R4 both entries
        8'b1_1_0_0_0_1_1_0, // R4
        8'b1_1_0_1_1_1_1_0, // R4
        8'b0_1_0_1_1_1_1_0, // R5
        8'b0_1_0_0_0_1_1_0, // R5
        8'b0_1_1_1_0_1_1_1, // R10 split left with frame
        8'b1_0_1_0_0_1_0_0, // R8 step and blank together
        8'b1_0_1_0_0_0_1_0, // R9 release, no step
        8'b1_0_1_0_0_1_1_0, // R9 first step after release
        8'b1_0_0_0_0_1_1_1, // R10
        8'b0_0_0_1_0_1_1_0  // R3
    };

    function automatic string tag_of(logic [7:0] v);
        if (!v[1])      return "R8";
        else if (!v[2]) return "R7";
        else if (v[0])  return "R10";
        else if (v[6])  return v[7] ? "R4" : "R5";
        else            return v[7] ? "R2" : "R3";
    endfunction

    task automatic check_rows(string tag);
        int bad = 0;
        logic [1:0] got1 = 2'b00, exp1 = 2'b00;
        int row1 = 0;
        for (int r = 0; r < ROWS; r++) begin
            logic [1:0] e;
            e = (blank_n && !mhold) ? {1'b1, mdl[r] ^ frame_inv} : 2'b00;
            if (row_code[2*r +: 2] !== e) begin
                if (bad == 0) begin got1 = row_code[2*r +: 2]; exp1 = e; row1 = r + 1; end
                bad++;
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s row %0d code actual %b expected %b (%0d rows wrong)", tag, row1, got1, exp1, bad);
        end
    endtask

    task automatic check_pins();
        logic [3:0] got, exp;
        got = {edge_a_oe, edge_b_oe, (dir_right ? edge_b_out : edge_a_out), 1'b0};
        exp = {!dir_right, dir_right, (dir_right ? mdl[ROWS-1] : mdl[0]), 1'b0};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R6 pins {a_oe,b_oe,out} actual %b expected %b", got[3:1], exp[3:1]);
        end
    endtask

    task automatic apply(logic [7:0] v, string tag);
        @(negedge clk);
        {dir_right, split_mode, edge_a_in, edge_b_in, split_in, step, blank_n, frame_inv} = v;
        @(posedge clk);
        if (!v[1]) begin
            mdl = '0; mhold = 1'b1;
        end else if (v[2]) begin
            mhold = 1'b0;
            if (v[7]) begin
                mdl = {mdl[ROWS-2:0], v[5]};
                if (v[6]) mdl[HALF] = v[3];
            end else begin
                mdl = {v[4], mdl[ROWS-1:1]};
                if (v[6]) mdl[HALF-1] = v[3];
            end
        end
        #2;
        check_rows(tag == "" ? tag_of(v) : tag);
        check_pins();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check_rows("R1");
        check_pins();
        // R1: first step after reset with a 0 entering: all rows plain
        apply(8'b1_0_0_0_0_1_1_0, "R1");
        for (int i = 0; i < NV; i++) apply(VEC[i], "");
        // R4: walk a 1 to row HALF, then verify it does not cross the boundary
        apply(8'b1_0_0_0_0_1_0_0, "R8");
        apply(8'b1_1_1_0_0_1_1_0, "R4");
        for (int k = 0; k < HALF - 1; k++) apply(8'b1_1_0_0_0_1_1_0, "R4");
        apply(8'b1_1_0_0_0_1_1_0, "R4");
        // R5: walk a 1 down to row HALF+1, then verify it stops there
        apply(8'b0_0_0_0_0_1_0_0, "R8");
        apply(8'b0_1_0_1_0_1_1_0, "R5");
        for (int k = 0; k < HALF; k++) apply(8'b0_1_0_0_0_1_1_0, "R5");
        // R2/R6: single mode right walk to the top row and out of the far end
        apply(8'b1_0_0_0_0_1_0_0, "R8");
        apply(8'b1_0_1_0_0_1_1_0, "R2");
        for (int k = 0; k < ROWS; k++) apply(8'b1_0_0_0_0_1_1_0, "R6");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule